// File: doc/BRIEF.md
# Subclock-to-Active Direct Transfer Sequencer

This block moves the system out of the slow, subclock-driven active state and into one of two fast active states without passing through a standby state in between. A software sleep request starts the move. The block first checks a combination of mode-control bits. If the combination allows a direct transfer, it counts three states in the subclock domain: two for the sleep operation and one for internal processing. It then switches the clock selection once. It waits for an oscillator-settling interval measured in states of the new system clock. Last, it holds a fixed 14-state window for interrupt exception handling, and then it reports the new mode.

The block does not generate clocks. It receives single-cycle enable ticks from the two clock sources: one tick for each oscillator cycle and one tick for each watch-clock cycle. One subclock state lasts `SUB_DIV` watch-clock cycles, which is 8 by default. One system-clock state lasts 2 oscillator cycles in the high-speed target and 16 oscillator cycles in the medium-speed target. Two elapsed-cycle counters report how many watch-clock cycles and how many oscillator cycles were spent in each domain. These counters let the two-domain transfer time be checked directly.

Top module: `mode_xfer_seq`

## Requirements
- R1: A sleep request that arrives while the block is idle in subclock mode (mode 0) starts a transfer only if all four conditions hold: `stby_en`=1, `lowspd_on`=0, `direct_on`=1 and `tmr_mode`=1. When the transfer starts, `busy` is 1 in the cycle after the request.
- R2: A sleep request that fails the condition in R1 leaves `busy` at 0, `mode` at 0 and `clk_sel` at 0.
- R3: The value of `medspd_on` at the request picks the target. A value of 1 gives mode 2 (medium speed) and a value of 0 gives mode 1 (high speed). `mode` keeps the value 0 while `busy` is 1 and takes the target value in the same cycle that `busy` falls.
- R4: The pre-switch phase lasts 3 subclock states of `SUB_DIV` watch ticks each. When the transfer completes, `watch_cnt` equals 3*`SUB_DIV`.
- R5: The wait length is sampled from `wait_sel` at the request. The values 0, 1, 2 and 3 select `WAIT_BASE`×1, ×2, ×4 and ×8 states. The values 4 to 7 select `WAIT_BASE`×16 states.
- R6: After the wait, the exception window lasts 14 system states. When the transfer completes, `osc_cnt` equals (wait states + 14) × oscillator cycles per state.
- R7: One system state lasts `HI_DIV` (2) oscillator ticks in the high-speed target and `MED_DIV` (16) oscillator ticks in the medium-speed target. `clk_sel` encodes the source as 0 for the subclock, 1 for oscillator/2 and 2 for oscillator/16.
- R8: During one transfer, `clk_sel` changes exactly once. The change happens on the edge that counts the last watch tick of the pre-switch phase.
- R9: A sleep request while `busy` is 1 is ignored. This includes any change to `wait_sel` at that time: it has no effect on the timing of the transfer in progress.
- R10: After completion, `busy` is 0 and both counters hold their values. A further sleep request leaves the block idle, because only subclock mode can start a transfer.
- R11: After reset, `mode`, `clk_sel`, `busy`, `watch_cnt` and `osc_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Single-cycle sleep request strobe |
| stby_en | input | 1 | Standby-enable control bit |
| lowspd_on | input | 1 | Low-speed-on control bit |
| direct_on | input | 1 | Direct-transfer-enable control bit |
| medspd_on | input | 1 | Target select: 1 selects medium speed, 0 selects high speed |
| tmr_mode | input | 1 | Timer-mode control bit |
| wait_sel | input | 3 | Settling-wait select |
| osc_tick | input | 1 | One pulse per oscillator cycle |
| watch_tick | input | 1 | One pulse per watch-clock cycle |
| mode | output | 2 | Current mode: 0 subclock, 1 high speed, 2 medium speed |
| clk_sel | output | 2 | Selected clock source code |
| busy | output | 1 | A transfer is in progress |
| watch_cnt | output | W_CNT_W | Watch-clock cycles elapsed in the current or last transfer |
| osc_cnt | output | O_CNT_W | Oscillator cycles elapsed in the current or last transfer |

## Verification
`busy` rises one clock edge after the request edge. `clk_sel` changes on the same edge that counts the last pre-switch watch tick, and `watch_cnt` reaches its final value on that same edge. `mode` and `osc_cnt` take their final values on the edge where `busy` falls, which is the edge that counts the last oscillator tick of the exception window. The bench drives inputs on falling edges and samples outputs on falling edges. As a result, every check sees the value registered on the preceding rising edge. The bench waits for `busy` to fall before it compares the counters. The tick patterns are random, so the number of cycles varies from run to run, but the final tick totals do not.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {MODE_SUB = 2'd0, MODE_HIGH = 2'd1, MODE_MED = 2'd2} xmode_e;
  typedef enum logic [1:0] {PH_RUN = 2'd0, PH_PRE = 2'd1, PH_WAIT = 2'd2, PH_EXC = 2'd3} phase_e;

  localparam int PRE_STATES = 3;   // sleep execution (2) + internal processing (1)
  localparam int EXC_STATES = 14;  // interrupt exception window

  // Settling wait in system states for a select code.
  function automatic int unsigned wait_states(input logic [2:0] sel, input int unsigned base);
    if (sel[2]) return base << 4;
    return base << sel[1:0];
  endfunction

  // Oscillator cycles per system state for a target mode.
  function automatic int unsigned osc_per_state(input logic med, input int unsigned hi_div,
                                                input int unsigned med_div);
    return med ? med_div : hi_div;
  endfunction
endpackage

// File: rtl/xfer_cond.sv
module xfer_cond (
  input  logic       stby_en,
  input  logic       lowspd_on,
  input  logic       direct_on,
  input  logic       tmr_mode,
  input  logic       medspd_on,
  output logic       cond_ok,
  output logic [1:0] tgt
);
  import xfer_pkg::*;
  assign cond_ok = stby_en & ~lowspd_on & direct_on & tmr_mode;
  assign tgt     = medspd_on ? MODE_MED : MODE_HIGH;
endmodule

// File: rtl/xfer_div.sv
module xfer_div #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic          state_end
);
  logic [PW-1:0] cnt_q;

  assign state_end = tick & ~clr & (cnt_q == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr || state_end) cnt_q <= '0;
    else if (tick)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mode_xfer_seq.sv
module mode_xfer_seq #(
  parameter int WAIT_BASE = 8192,
  parameter int HI_DIV    = 2,
  parameter int MED_DIV   = 16,
  parameter int SUB_DIV   = 8,
  localparam int MAX_WAIT = WAIT_BASE * 16,
  localparam int W_CNT_W  = $clog2(xfer_pkg::PRE_STATES * SUB_DIV + 1),
  localparam int O_CNT_W  = $clog2((MAX_WAIT + xfer_pkg::EXC_STATES) * MED_DIV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req,
  input  logic               stby_en,
  input  logic               lowspd_on,
  input  logic               direct_on,
  input  logic               medspd_on,
  input  logic               tmr_mode,
  input  logic [2:0]         wait_sel,
  input  logic               osc_tick,
  input  logic               watch_tick,
  output logic [1:0]         mode,
  output logic [1:0]         clk_sel,
  output logic               busy,
  output logic [W_CNT_W-1:0] watch_cnt,
  output logic [O_CNT_W-1:0] osc_cnt
);
  import xfer_pkg::*;

  localparam int ST_W    = $clog2(MAX_WAIT + 1);
  localparam int DIV_MAX = (MED_DIV > SUB_DIV) ? MED_DIV : SUB_DIV;
  localparam int DIV_W   = $clog2(DIV_MAX + 1);

  phase_e            ph_q;
  logic [1:0]        mode_q, sel_q, tgt_q;
  logic [ST_W-1:0]   st_q, wlen_q;
  logic              cond_ok;
  logic [1:0]        tgt_now;

  // Named internal events.
  logic              start_xfer, sub_state_end, sys_state_end;
  logic              pre_last, wait_last, exc_last, in_sys;
  logic [DIV_W-1:0]  sys_period;

  xfer_cond u_cond (
    .stby_en  (stby_en),
    .lowspd_on(lowspd_on),
    .direct_on(direct_on),
    .tmr_mode (tmr_mode),
    .medspd_on(medspd_on),
    .cond_ok  (cond_ok),
    .tgt      (tgt_now)
  );

  assign in_sys     = (ph_q == PH_WAIT) || (ph_q == PH_EXC);
  assign sys_period = DIV_W'(osc_per_state(tgt_q == MODE_MED, HI_DIV, MED_DIV));

  xfer_div #(.PW(DIV_W)) u_sub_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ph_q != PH_PRE),
    .tick     (watch_tick),
    .period   (DIV_W'(SUB_DIV)),
    .state_end(sub_state_end)
  );

  xfer_div #(.PW(DIV_W)) u_sys_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (~in_sys),
    .tick     (osc_tick),
    .period   (sys_period),
    .state_end(sys_state_end)
  );

  assign start_xfer = sleep_req & (ph_q == PH_RUN) & (mode_q == MODE_SUB) & cond_ok;
  assign pre_last   = (ph_q == PH_PRE)  & sub_state_end & (st_q == ST_W'(PRE_STATES - 1));
  assign wait_last  = (ph_q == PH_WAIT) & sys_state_end & (st_q == wlen_q - 1'b1);
  assign exc_last   = (ph_q == PH_EXC)  & sys_state_end & (st_q == ST_W'(EXC_STATES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_RUN;
      mode_q <= MODE_SUB;
      sel_q  <= MODE_SUB;
      tgt_q  <= MODE_HIGH;
      st_q   <= '0;
      wlen_q <= '0;
    end else begin
      unique case (ph_q)
        PH_RUN: if (start_xfer) begin
          ph_q   <= PH_PRE;
          tgt_q  <= tgt_now;
          wlen_q <= ST_W'(wait_states(wait_sel, WAIT_BASE));
          st_q   <= '0;
        end
        PH_PRE: if (pre_last) begin
          ph_q  <= PH_WAIT;
          sel_q <= tgt_q;
          st_q  <= '0;
        end else if (sub_state_end) st_q <= st_q + 1'b1;
        PH_WAIT: if (wait_last) begin
          ph_q <= PH_EXC;
          st_q <= '0;
        end else if (sys_state_end) st_q <= st_q + 1'b1;
        PH_EXC: if (exc_last) begin
          ph_q   <= PH_RUN;
          mode_q <= tgt_q;
          st_q   <= '0;
        end else if (sys_state_end) st_q <= st_q + 1'b1;
        default: ph_q <= PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      watch_cnt <= '0;
      osc_cnt   <= '0;
    end else if (start_xfer) begin
      watch_cnt <= '0;
      osc_cnt   <= '0;
    end else begin
      if (ph_q == PH_PRE && watch_tick) watch_cnt <= watch_cnt + 1'b1;
      if (in_sys && osc_tick)           osc_cnt   <= osc_cnt + 1'b1;
    end
  end

  assign mode    = mode_q;
  assign clk_sel = sel_q;
  assign busy    = (ph_q != PH_RUN);
endmodule

// File: rtl/xfer_chk.sv
module xfer_chk #(
  parameter int SUB_DIV = 8,
  parameter int W_W     = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sleep_req,
  input logic           stby_en,
  input logic           lowspd_on,
  input logic           direct_on,
  input logic           tmr_mode,
  input logic [1:0]     mode,
  input logic [1:0]     clk_sel,
  input logic           busy,
  input logic [W_W-1:0] watch_cnt
);
  logic allowed;
  assign allowed = stby_en & ~lowspd_on & direct_on & tmr_mode;

  // R1: a qualified request from idle subclock mode starts a transfer
  a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !busy && allowed && mode == 2'd0) |=> busy);

  // R2: an unqualified request starts nothing
  a_r2_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !busy && !allowed) |=> !busy);

  // R3: mode stays subclock through the transfer
  a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode == 2'd0));

  // R3 / R7: at completion, mode matches the clock source already selected
  a_r3_end_match: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mode == clk_sel && mode != 2'd0));

  // R4: pre-switch watch count never exceeds three subclock states
  a_r4_watch_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (watch_cnt <= W_W'(3 * SUB_DIV)));

  // R8: the clock select moves only at the pre-switch boundary
  a_r8_sel_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel) |-> (busy && watch_cnt == W_W'(3 * SUB_DIV)));

  // R9: a request while busy does not restart the pre-switch count
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sleep_req) |=> (watch_cnt >= $past(watch_cnt)));
endmodule

bind mode_xfer_seq xfer_chk #(.SUB_DIV(SUB_DIV), .W_W(W_CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sleep_req(sleep_req),
  .stby_en  (stby_en),
  .lowspd_on(lowspd_on),
  .direct_on(direct_on),
  .tmr_mode (tmr_mode),
  .mode     (mode),
  .clk_sel  (clk_sel),
  .busy     (busy),
  .watch_cnt(watch_cnt)
);

// File: tb/sim_mode_xfer_seq.sv
module sim_mode_xfer_seq;
  localparam int WB  = 4;
  localparam int HI  = 2;
  localparam int MED = 16;
  localparam int SUB = 8;
  localparam int W_W = $clog2(3 * SUB + 1);
  localparam int O_W = $clog2((WB * 16 + 14) * MED + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, stby_en = 1'b0, lowspd_on = 1'b0, direct_on = 1'b0;
  logic medspd_on = 1'b0, tmr_mode = 1'b0, osc_tick = 1'b0, watch_tick = 1'b0;
  logic [2:0] wait_sel = 3'd0;
  logic [1:0] mode, clk_sel;
  logic busy;
  logic [W_W-1:0] watch_cnt;
  logic [O_W-1:0] osc_cnt;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  mode_xfer_seq #(.WAIT_BASE(WB), .HI_DIV(HI), .MED_DIV(MED), .SUB_DIV(SUB)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_en(stby_en),
    .lowspd_on(lowspd_on), .direct_on(direct_on), .medspd_on(medspd_on),
    .tmr_mode(tmr_mode), .wait_sel(wait_sel), .osc_tick(osc_tick),
    .watch_tick(watch_tick), .mode(mode), .clk_sel(clk_sel), .busy(busy),
    .watch_cnt(watch_cnt), .osc_cnt(osc_cnt)
  );

  function automatic int exp_wait(input logic [2:0] s);
    int m;
    case (s)
      3'd0: m = 1;
      3'd1: m = 2;
      3'd2: m = 4;
      3'd3: m = 8;
      default: m = 16;
    endcase
    return WB * m;
  endfunction

  function automatic int exp_osc(input logic [2:0] s, input bit med);
    return (exp_wait(s) + 14) * (med ? MED : HI);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle of random ticks, then land on the next falling edge
  task automatic step(input bit slp);
    osc_tick   = ($urandom % 4) != 0;
    watch_tick = ($urandom % 4) == 0;
    sleep_req  = slp;
    if (slp) wait_sel = ~wait_sel;
    @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; sleep_req = 1'b0; osc_tick = 1'b0; watch_tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic trial(input bit sb, input bit ls, input bit dt, input bit ms,
                       input bit tm, input logic [2:0] ws, input bit poke);
    bit ok;
    int changes, wat, n;
    logic [1:0] prev, tgt;
    int held;
    do_reset;
    chk(busy == 0 && mode == 0 && clk_sel == 0, "R11 reset outputs", {busy, mode, clk_sel}, 0);
    chk(watch_cnt == 0 && osc_cnt == 0, "R11 reset counters", int'(osc_cnt) + int'(watch_cnt), 0);
    stby_en = sb; lowspd_on = ls; direct_on = dt; medspd_on = ms; tmr_mode = tm;
    wait_sel = ws; sleep_req = 1'b1; osc_tick = 1'b0; watch_tick = 1'b0;
    @(negedge clk);
    sleep_req = 1'b0;
    ok = sb && !ls && dt && tm;
    tgt = ms ? 2'd2 : 2'd1;
    chk(busy == ok, ok ? "R1 busy after request" : "R2 busy after bad request", busy, ok);
    if (!ok) begin
      repeat (30) step(1'b0);
      chk(mode == 0 && busy == 0 && clk_sel == 0, "R2 no effect", {busy, mode, clk_sel}, 0);
    end else begin
      changes = 0; wat = -1; prev = clk_sel; n = 0;
      while (busy && n < 20000) begin
        step(poke && (n == 3 || n == 150));
        n++;
        if (clk_sel != prev) begin
          changes++;
          wat = watch_cnt;
          prev = clk_sel;
        end
        if (busy) chk(mode == 0, "R3 mode held while busy", mode, 0);
      end
      chk(!busy, "R6 transfer completes", busy, 0);
      chk(mode == tgt, "R3 target mode", mode, tgt);
      chk(clk_sel == tgt, "R7 clock select code", clk_sel, tgt);
      chk(changes == 1, "R8 single select change", changes, 1);
      chk(wat == 3 * SUB, "R8 change at pre-switch end", wat, 3 * SUB);
      chk(watch_cnt == 3 * SUB, "R4 watch cycles", watch_cnt, 3 * SUB);
      chk(osc_cnt == exp_osc(ws, ms), poke ? "R9 R5 R6 oscillator cycles" : "R5 R6 oscillator cycles",
          osc_cnt, exp_osc(ws, ms));
      held = osc_cnt;
      stby_en = 1'b1; lowspd_on = 1'b0; direct_on = 1'b1; tmr_mode = 1'b1;
      step(1'b1);
      repeat (20) step(1'b0);
      chk(!busy && mode == tgt && osc_cnt == held && watch_cnt == 3 * SUB,
          "R10 idle after completion", {busy, mode}, tgt);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // directed: every wait code, both targets; some with requests while busy (R9)
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 2; m++) trial(1, 0, 1, m[0], 1, 3'(s), (s % 3) == 0);
    end
    // directed: each single condition bit wrong (R2)
    trial(0, 0, 1, 0, 1, 3'd0, 0);
    trial(1, 1, 1, 0, 1, 3'd0, 0);
    trial(1, 0, 0, 1, 1, 3'd1, 0);
    trial(1, 0, 1, 1, 0, 3'd2, 0);
    // random mix biased toward qualified requests
    for (int i = 0; i < 20; i++) begin
      trial(($urandom % 6) != 0, ($urandom % 6) == 0, ($urandom % 6) != 0,
            1'($urandom), ($urandom % 6) != 0, 3'($urandom), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule